// File: doc/BRIEF.md
# SCSI Host DMA Channel Register Set

This block holds the control and status registers of a bus-master DMA channel in a SCSI host adapter. Software programs a transfer through a small indexed register port. It writes a starting byte count, a starting memory address and a starting descriptor-list address, then issues a start command. The start command copies those values into working registers and turns the channel on toward the SCSI core. The core then moves data in chunks through a request/acknowledge handshake. For each chunk the block clips the length to the bytes still owed, reduces the working count, advances the working address, and flags completion when the count reaches zero.

A command field selects one of four operations:
- idle turns the channel off;
- blast is accepted and does nothing;
- abort turns the channel off, pulses a cancel request to the core and records an abort flag;
- start reloads the working registers and turns the channel on.

The status register clears its completion-type flags in one of two ways. A mode bit in a separate bus-control register chooses between clearing on write-one and clearing on read. While the SCSI core's interrupt is pending, the status read also shows it. An interrupt output follows the done flag when the done-interrupt enable is set.

The control flow is a two-state machine:
- OFF is entered at reset, on an idle command and on an abort command.
- RUN is entered on a start command. A start issued in RUN stays in RUN and reloads the working registers.
- A blast command leaves either state unchanged.

Chunk requests are accepted only in RUN.

Top module: `scsi_dma_regs`

## Requirements
- R1: After reset every register reads 0, except working address, which reads 0xFFFFFFFF, and working descriptor address, which reads 0xFFFFFFFD. `dma_en`, `irq` and `chk_ack` are low.
- R2: A write to index 0 with low bits 3 (start) copies index 1 to index 3, index 2 to index 4 and index 6 to index 7. It clears status bits 0 to 5 and raises `dma_en` in the next cycle.
- R3: Command value 0 (idle) drops `dma_en`. Command value 1 (blast) changes neither `dma_en` nor any working register.
- R4: Command value 2 (abort) drives `cancel_req` high in the write cycle, drops `dma_en` and sets status bit 2 (abort).
- R5: An accepted chunk is acknowledged one cycle after the request, with `chk_gnt` equal to min(`chk_len`, working count). The working count falls by `chk_gnt` and the working address rises by it.
- R6: When an accepted chunk brings the working count to zero, status bit 3 (done) sets. `irq` equals done AND command bit 6.
- R7: A chunk request is ignored (no acknowledge, no register change) when its `chk_to_mem` differs from command bit 7 (1 = device to memory) or when `dma_en` is low.
- R8: With bus-control (index 8) bit 24 set, a status write clears those of bits 1, 2 and 3 whose write-data bit is 1, and a status read clears nothing.
- R9: With bus-control bit 24 clear, a status read returns the current value and then clears bits 1, 2 and 3.
- R10: A status read shows bit 4 set whenever `core_irq` is high.
- R11: A `cmd_done` pulse forces the working count to 0 and sets status bit 3.
- R12: Writes to indices 3, 4 and 7 are ignored. Index 8 is a plain read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used for clear-on-read) |
| reg_idx | input | 4 | Register index, 0 to 8 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx`, combinational |
| core_irq | input | 1 | SCSI core interrupt pending |
| cmd_done | input | 1 | SCSI command completed pulse |
| chk_req | input | 1 | Chunk transfer request from the core |
| chk_to_mem | input | 1 | Chunk direction, 1 = device to memory |
| chk_len | input | 24 | Requested chunk length in bytes |
| chk_ack | output | 1 | Chunk accepted, one cycle after the request |
| chk_gnt | output | 32 | Clipped length granted with `chk_ack` |
| dma_en | output | 1 | Channel enabled toward the core (RUN state) |
| cancel_req | output | 1 | Cancel the active core request (abort) |
| irq | output | 1 | Done interrupt |

## Verification
Any fault in the working count, the working address or the status flags shows up on `reg_rdata` no later than the next cycle for that index. The bench compares it every clock against a behavioural model. A wrong state-machine state appears on `dma_en` in the cycle after the offending command. It also shows one cycle later as a missing or unexpected `chk_ack`. A wrong clip shows on `chk_gnt` in the acknowledge cycle, and afterwards as a drifting count and address.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;
    typedef enum logic [0:0] {ST_OFF = 1'b0, ST_RUN = 1'b1} dma_state_e;
    typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_BLAST = 2'd1,
                              OP_ABORT = 2'd2, OP_START = 2'd3} dma_op_e;

    localparam int IX_CMD  = 0;
    localparam int IX_SCNT = 1;
    localparam int IX_SADR = 2;
    localparam int IX_WCNT = 3;
    localparam int IX_WADR = 4;
    localparam int IX_STAT = 5;
    localparam int IX_SLST = 6;
    localparam int IX_WLST = 7;
    localparam int IX_BCTL = 8;

    localparam int STAT_W   = 6;
    localparam int SB_ERR   = 1;
    localparam int SB_ABT   = 2;
    localparam int SB_DONE  = 3;
    localparam int SB_SINT  = 4;
    localparam int CB_DONE_IE = 6;
    localparam int CB_DIR   = 7;
    localparam int BC_W1C   = 24;
endpackage

// File: rtl/dma_cmd_fsm.sv
module dma_cmd_fsm
    import scsi_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [1:0] op,
    output logic       run,
    output logic       load,
    output logic       abort_hit
);
    dma_state_e state, state_nx;
    dma_op_e    op_e;

    assign op_e = dma_op_e'(op);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (cmd_wr && op_e == OP_START) state_nx = ST_RUN;
            ST_RUN: if (cmd_wr && (op_e == OP_IDLE || op_e == OP_ABORT)) state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        run       = (state == ST_RUN);
        load      = cmd_wr && (op_e == OP_START);
        abort_hit = cmd_wr && (op_e == OP_ABORT);
    end
endmodule

// File: rtl/dma_xfer_track.sv
module dma_xfer_track #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] start_cnt,
    input  logic [DATA_W-1:0] start_adr,
    input  logic [DATA_W-1:0] start_lst,
    input  logic              step,
    input  logic [LEN_W-1:0]  step_len,
    input  logic              zero_cnt,
    output logic [DATA_W-1:0] wcnt,
    output logic [DATA_W-1:0] wadr,
    output logic [DATA_W-1:0] wlst,
    output logic [DATA_W-1:0] gnt_len,
    output logic              hits_zero
);
    localparam logic [DATA_W-1:0] WADR_RST = '1;
    localparam logic [DATA_W-1:0] WLST_RST = ~DATA_W'(2);

    logic [DATA_W-1:0] len_ext;

    assign len_ext   = DATA_W'(step_len);
    assign gnt_len   = (len_ext < wcnt) ? len_ext : wcnt;
    assign hits_zero = (wcnt == gnt_len);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            wadr <= WADR_RST;
            wlst <= WLST_RST;
        end else if (load) begin
            wcnt <= start_cnt;
            wadr <= start_adr;
            wlst <= start_lst;
        end else if (zero_cnt) begin
            wcnt <= '0;
        end else if (step) begin
            wcnt <= wcnt - gnt_len;
            wadr <= wadr + gnt_len;
        end
    end
endmodule

// File: rtl/dma_stat_reg.sv
module dma_stat_reg
    import scsi_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic [STAT_W-1:0] set_mask,
    output logic [STAT_W-1:0] stat
);
    logic [STAT_W-1:0] kept;

    assign kept = clr_all ? '0 : (stat & ~clr_mask);

    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= kept | set_mask;
    end
endmodule

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
    import scsi_dma_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 24,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              core_irq,
    input  logic              cmd_done,
    input  logic              chk_req,
    input  logic              chk_to_mem,
    input  logic [LEN_W-1:0]  chk_len,
    output logic              chk_ack,
    output logic [DATA_W-1:0] chk_gnt,
    output logic              dma_en,
    output logic              cancel_req,
    output logic              irq
);
    localparam logic [STAT_W-1:0] CLR_SET = STAT_W'((1 << SB_ERR) | (1 << SB_ABT) | (1 << SB_DONE));

    logic [DATA_W-1:0] cmd_q, scnt_q, sadr_q, slst_q, bctl_q;
    logic [DATA_W-1:0] wcnt, wadr, wlst, gnt_len;
    logic [STAT_W-1:0] stat, clr_mask, set_mask;
    logic              run, load, abort_hit, hits_zero, chunk_ok;
    logic              cmd_wr, stat_wr, stat_rd;
    logic [DATA_W-1:0] stat_view;

    assign cmd_wr  = reg_wr && (reg_idx == IDX_W'(IX_CMD));
    assign stat_wr = reg_wr && (reg_idx == IDX_W'(IX_STAT));
    assign stat_rd = reg_rd && (reg_idx == IDX_W'(IX_STAT));

    dma_cmd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .op(reg_wdata[1:0]),
        .run(run), .load(load), .abort_hit(abort_hit)
    );

    assign chunk_ok = chk_req && run && (chk_to_mem == cmd_q[CB_DIR]) && !load;

    dma_xfer_track #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_track (
        .clk(clk), .rst_n(rst_n), .load(load),
        .start_cnt(scnt_q), .start_adr(sadr_q), .start_lst(slst_q),
        .step(chunk_ok), .step_len(chk_len), .zero_cnt(cmd_done),
        .wcnt(wcnt), .wadr(wadr), .wlst(wlst),
        .gnt_len(gnt_len), .hits_zero(hits_zero)
    );

    always_comb begin
        clr_mask = '0;
        if (bctl_q[BC_W1C]) begin
            if (stat_wr) clr_mask = reg_wdata[STAT_W-1:0] & CLR_SET;
        end else if (stat_rd) begin
            clr_mask = CLR_SET;
        end
        set_mask = '0;
        set_mask[SB_DONE] = (chunk_ok && hits_zero) || cmd_done;
        set_mask[SB_ABT]  = abort_hit;
    end

    dma_stat_reg u_stat (
        .clk(clk), .rst_n(rst_n), .clr_all(load),
        .clr_mask(clr_mask), .set_mask(set_mask), .stat(stat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            scnt_q  <= '0;
            sadr_q  <= '0;
            slst_q  <= '0;
            bctl_q  <= '0;
            chk_ack <= 1'b0;
            chk_gnt <= '0;
        end else begin
            if (cmd_wr) cmd_q <= reg_wdata;
            if (reg_wr && reg_idx == IDX_W'(IX_SCNT)) scnt_q <= reg_wdata;
            if (reg_wr && reg_idx == IDX_W'(IX_SADR)) sadr_q <= reg_wdata;
            if (reg_wr && reg_idx == IDX_W'(IX_SLST)) slst_q <= reg_wdata;
            if (reg_wr && reg_idx == IDX_W'(IX_BCTL)) bctl_q <= reg_wdata;
            chk_ack <= chunk_ok;
            chk_gnt <= chunk_ok ? gnt_len : '0;
        end
    end

    always_comb begin
        stat_view = DATA_W'(stat);
        stat_view[SB_SINT] = stat[SB_SINT] | core_irq;
    end

    always_comb begin
        case (reg_idx)
            IDX_W'(IX_CMD):  reg_rdata = cmd_q;
            IDX_W'(IX_SCNT): reg_rdata = scnt_q;
            IDX_W'(IX_SADR): reg_rdata = sadr_q;
            IDX_W'(IX_WCNT): reg_rdata = wcnt;
            IDX_W'(IX_WADR): reg_rdata = wadr;
            IDX_W'(IX_STAT): reg_rdata = stat_view;
            IDX_W'(IX_SLST): reg_rdata = slst_q;
            IDX_W'(IX_WLST): reg_rdata = wlst;
            IDX_W'(IX_BCTL): reg_rdata = bctl_q;
            default:         reg_rdata = '0;
        endcase
    end

    assign dma_en     = run;
    assign cancel_req = abort_hit;
    assign irq        = stat[SB_DONE] & cmd_q[CB_DONE_IE];
endmodule

// File: rtl/scsi_dma_regs_chk.sv
module scsi_dma_regs_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [1:0]        cmd_op,
    input logic              dma_en,
    input logic              cancel_req,
    input logic              chk_req,
    input logic              chk_ack,
    input logic [DATA_W-1:0] chk_gnt,
    input logic [DATA_W-1:0] wcnt,
    input logic              cmd_done
);
    logic start_wr;
    assign start_wr = reg_wr && (reg_idx == '0) && (cmd_op == 2'd3);

    // R2
    start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> dma_en);

    // R4
    cancel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_req |=> !dma_en);

    // R5
    grant_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_ack |-> (chk_gnt <= $past(wcnt)));

    // R7
    off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_req && !dma_en) |=> !chk_ack);

    // R11
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !start_wr) |=> (wcnt == '0));
endmodule

bind scsi_dma_regs scsi_dma_regs_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .cmd_op(reg_wdata[1:0]), .dma_en(dma_en), .cancel_req(cancel_req),
    .chk_req(chk_req), .chk_ack(chk_ack), .chk_gnt(chk_gnt),
    .wcnt(wcnt), .cmd_done(cmd_done)
);

// File: tb/scsi_dma_regs_bench.sv
`timescale 1ns/1ps
module scsi_dma_regs_bench;
    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_rd = 0, core_irq = 0, cmd_done = 0;
    logic        chk_req = 0, chk_to_mem = 0;
    logic [3:0]  reg_idx = 0;
    logic [31:0] reg_wdata = 0;
    logic [23:0] chk_len = 0;
    logic [31:0] reg_rdata, chk_gnt;
    logic        chk_ack, dma_en, cancel_req, irq;

    int n_chk = 0, n_fail = 0;
    string cur_tag = "R1";
    logic seen_cancel;
    logic [31:0] rd_val;

    always #4 clk = ~clk;

    scsi_dma_regs u_scsi_dma_regs (.*);

    // behavioural reference model
    logic [31:0] m_r[0:8];
    logic [5:0]  m_stat;
    logic        m_run, m_ack;
    logic [31:0] m_gnt;
    logic        e_ld, e_ab, e_ok;
    logic [31:0] e_g;
    logic [5:0]  e_clr, e_set;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) m_r[i] = 0;
            m_r[4] = 32'hFFFF_FFFF; m_r[7] = 32'hFFFF_FFFD;
            m_stat = 0; m_run = 0; m_ack = 0; m_gnt = 0;
        end else begin
            e_ld = reg_wr && reg_idx == 0 && reg_wdata[1:0] == 3;
            e_ab = reg_wr && reg_idx == 0 && reg_wdata[1:0] == 2;
            e_ok = chk_req && m_run && (chk_to_mem == m_r[0][7]) && !e_ld;
            e_g  = ({8'd0, chk_len} < m_r[3]) ? {8'd0, chk_len} : m_r[3];
            e_clr = 0; e_set = 0;
            if (m_r[8][24] && reg_wr && reg_idx == 5) e_clr = reg_wdata[5:0] & 6'b001110;
            if (!m_r[8][24] && reg_rd && reg_idx == 5) e_clr = 6'b001110;
            if ((e_ok && m_r[3] == e_g) || cmd_done) e_set[3] = 1;
            if (e_ab) e_set[2] = 1;
            m_stat = (e_ld ? 6'd0 : (m_stat & ~e_clr)) | e_set;
            if (e_ld) begin
                m_r[3] = m_r[1]; m_r[4] = m_r[2]; m_r[7] = m_r[6];
            end else if (cmd_done) m_r[3] = 0;
            else if (e_ok) begin
                m_r[3] = m_r[3] - e_g; m_r[4] = m_r[4] + e_g;
            end
            m_ack = e_ok; m_gnt = e_ok ? e_g : 0;
            if (reg_wr && reg_idx == 0) begin
                if (reg_wdata[1:0] == 3) m_run = 1;
                else if (reg_wdata[1:0] != 1) m_run = 0;
            end
            if (reg_wr && (reg_idx == 0 || reg_idx == 1 || reg_idx == 2 ||
                           reg_idx == 6 || reg_idx == 8)) m_r[reg_idx] = reg_wdata;
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] ix);
        if (ix == 5) return {26'd0, m_stat} | (core_irq ? 32'h10 : 32'h0);
        if (ix > 8) return 0;
        return m_r[ix];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // model comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            check({cur_tag, " model rdata"}, reg_rdata, m_read(reg_idx));
            check({cur_tag, " model ports"},
                  {28'd0, dma_en, irq, cancel_req, chk_ack},
                  {28'd0, m_run, m_stat[3] & m_r[0][6], e_ab_now(), m_ack});
            check({cur_tag, " model gnt"}, chk_gnt, m_gnt);
        end
    end

    function automatic logic e_ab_now();
        return reg_wr && reg_idx == 0 && reg_wdata[1:0] == 2;
    endfunction

    task automatic do_wr(input int ix, input logic [31:0] d);
        @(posedge clk); #2; reg_idx = ix[3:0]; reg_wdata = d; reg_wr = 1;
        @(negedge clk); seen_cancel = cancel_req;
        @(posedge clk); #2; reg_wr = 0;
    endtask

    task automatic do_rd(input int ix);
        @(posedge clk); #2; reg_idx = ix[3:0]; reg_rd = 1;
        @(negedge clk); rd_val = reg_rdata;
        @(posedge clk); #2; reg_rd = 0;
    endtask

    task automatic do_chunk(input logic dir, input int len, input string tag,
                            input logic exp_ack, input int exp_gnt);
        @(posedge clk); #2; chk_req = 1; chk_to_mem = dir; chk_len = len[23:0];
        @(posedge clk); #2; chk_req = 0;
        @(negedge clk);
        check({tag, " ack"}, {31'd0, chk_ack}, {31'd0, exp_ack});
        check({tag, " gnt"}, chk_gnt, exp_gnt);
    endtask

    task automatic peek(input int ix, input logic [31:0] exp, input string tag);
        @(posedge clk); #2; reg_idx = ix[3:0];
        @(negedge clk); check(tag, reg_rdata, exp);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1 reset values
        peek(0, 0, "R1 cmd"); peek(3, 0, "R1 wcnt");
        peek(4, 32'hFFFF_FFFF, "R1 wadr"); peek(7, 32'hFFFF_FFFD, "R1 wlst");
        peek(5, 0, "R1 stat");
        check("R1 dma_en", {31'd0, dma_en}, 0);
        // R12 working registers not writable, bus control is
        cur_tag = "R12";
        do_wr(3, 32'h55); do_wr(4, 32'h66); do_wr(7, 32'h77);
        peek(3, 0, "R12 wcnt"); peek(4, 32'hFFFF_FFFF, "R12 wadr");
        peek(7, 32'hFFFF_FFFD, "R12 wlst");
        do_wr(8, 32'h0100_0000); peek(8, 32'h0100_0000, "R12 bctl");
        // R2 start
        cur_tag = "R2";
        do_wr(1, 100); do_wr(2, 32'h1000); do_wr(6, 32'h2000);
        do_wr(0, 32'h43);
        peek(3, 100, "R2 wcnt"); peek(4, 32'h1000, "R2 wadr");
        peek(7, 32'h2000, "R2 wlst");
        check("R2 dma_en", {31'd0, dma_en}, 1);
        // R7 wrong direction
        cur_tag = "R7";
        do_chunk(1, 10, "R7 dir", 0, 0);
        peek(3, 100, "R7 wcnt");
        // R5 chunks and clipping, R6 done and irq
        cur_tag = "R5";
        do_chunk(0, 30, "R5 full", 1, 30);
        peek(3, 70, "R5 wcnt"); peek(4, 32'h101E, "R5 wadr");
        peek(5, 0, "R6 not done");
        do_chunk(0, 100, "R5 clip", 1, 70);
        cur_tag = "R6";
        peek(5, 8, "R6 done"); check("R6 irq", {31'd0, irq}, 1);
        // R8 write-one-clear mode
        cur_tag = "R8";
        do_rd(5); check("R8 read value", rd_val, 8);
        peek(5, 8, "R8 read keeps");
        do_wr(5, 32'h0); peek(5, 8, "R8 zero write");
        do_wr(5, 32'h8); peek(5, 0, "R8 w1c");
        check("R8 irq low", {31'd0, irq}, 0);
        // R10 core interrupt reflection
        cur_tag = "R10";
        @(posedge clk); #2 core_irq = 1;
        peek(5, 32'h10, "R10 sint");
        @(posedge clk); #2 core_irq = 0;
        peek(5, 0, "R10 sint off");
        // R3 blast and idle
        cur_tag = "R3";
        do_wr(0, 32'h41);
        check("R3 blast en", {31'd0, dma_en}, 1);
        peek(3, 0, "R3 blast wcnt"); peek(4, 32'h1064, "R3 blast wadr");
        do_wr(0, 32'h40);
        check("R3 idle en", {31'd0, dma_en}, 0);
        do_chunk(0, 4, "R7 off", 0, 0);
        // R4 abort
        cur_tag = "R4";
        do_wr(0, 32'h03); check("R4 restart", {31'd0, dma_en}, 1);
        do_wr(0, 32'h02);
        check("R4 cancel", {31'd0, seen_cancel}, 1);
        check("R4 dma_en", {31'd0, dma_en}, 0);
        peek(5, 4, "R4 abort flag");
        // R9 clear-on-read mode
        cur_tag = "R9";
        do_wr(8, 0);
        do_rd(5); check("R9 read value", rd_val, 4);
        peek(5, 0, "R9 cleared");
        // R11 command complete
        cur_tag = "R11";
        do_wr(0, 32'h43);
        @(posedge clk); #2 cmd_done = 1;
        @(posedge clk); #2 cmd_done = 0;
        peek(3, 0, "R11 wcnt"); peek(5, 8, "R11 done");
        check("R11 irq", {31'd0, irq}, 1);
        // R6 irq gated by enable, device-to-memory direction
        cur_tag = "R6";
        do_wr(1, 5); do_wr(0, 32'h83);
        do_chunk(1, 9, "R6 dir out", 1, 5);
        peek(5, 8, "R6 done2"); check("R6 irq gated", {31'd0, irq}, 0);
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule